// File: doc/BRIEF.md
# SPI Serial Memory Array Access Sequencer

This block sits behind the serial pins of a byte-wide non-volatile memory model. It decodes the array access instructions, which are a read and a page write, and drives a synchronous single-port RAM that holds the array. The serial clock, select and data input are brought into the system clock domain through synchronisers. Every edge is then handled as a one-cycle event. Bits are taken on the rising serial clock edge and moved out on the falling edge, most significant bit first.

A read sends the opcode, then one address byte, then streams array bytes for as long as select stays low. The address advances after every byte and wraps from the top of the array to zero. A write sends the opcode, one address byte and any number of data bytes. These bytes are collected in a 16-byte page buffer, and bytes past the end of the page wrap back to its first byte. The buffer is written to the RAM only after select rises. The block then stays busy for a programmable number of cycles and pulses a request to clear the write enable latch. The status logic supplies that latch and two protect bits, which mark the top quarter, the top half or the whole array as read-only.

States of the sequencer: IDLE (waiting for select to fall), OPCODE (collecting the instruction byte), ADDR (collecting the address byte), RD (streaming data out), WR (filling the page buffer), DISCARD (swallowing a refused or unknown instruction until select rises), COMMIT (one cycle per page slot, writing the filled slots to the RAM) and HOLDOFF (the programmed write time).

Transitions:
- IDLE→OPCODE on a select fall.
- OPCODE→ADDR on a read opcode, or on a write opcode while the latch is set.
- OPCODE→DISCARD for any other byte.
- ADDR→RD for a read.
- ADDR→WR for a write to an unprotected address.
- ADDR→DISCARD for a write to a protected address.
- WR→COMMIT on a select rise at a byte boundary with at least one data byte.
- WR→IDLE on any other select rise.
- COMMIT→HOLDOFF after the last page slot.
- HOLDOFF→IDLE when the count expires.
- OPCODE, ADDR, RD and DISCARD return to IDLE whenever select rises.

Top module: `spi_array_seq`

## Requirements
- R1: After reset, busy, the output enable, the latch-clear pulse and the RAM write enable are all 0.
- R2: Opcode 8'h03 followed by an address byte returns the array byte at that address, MSB first, then the following bytes in increasing address order for as long as select stays low.
- R3: The read address wraps from DEPTH-1 to 0 without stopping, and address bits at or above log2(DEPTH) are ignored (with DEPTH=128, bit 7 of the address byte has no effect).
- R4: Opcode 8'h02, an address byte and data bytes write those bytes starting at the address. No RAM write happens before select rises, and busy rises only while the synchronised select is high.
- R5: A write stays inside its 16-byte page (address bits [3:0] advance and wrap), so data bytes past the page end overwrite the first bytes of the same page.
- R6: A write is refused, leaving the array unchanged, when its address is in the protected region. Protect bits 2'b01 cover the top quarter, 2'b10 the top half, 2'b11 the whole array and 2'b00 nothing.
- R7: A write opcode received while the write enable latch input is 0 is refused.
- R8: A write is refused when select rises part-way through a byte, or when no complete data byte was received.
- R9: An accepted write keeps busy high for exactly 16 + WR_CYCLES cycles. Instructions that start while busy is high have no effect: there is no array change and the output is not enabled.
- R10: The output enable is 0 whenever select is high, during the opcode and address bytes, and for any opcode other than 8'h03 and 8'h02.
- R11: Each accepted write produces exactly one one-cycle latch-clear pulse, in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, valid while spi_miso_oe is 1 |
| spi_miso_oe | output | 1 | Output driver enable; 0 means the pin is high impedance |
| prot_bits | input | 2 | Protect bits from the status logic |
| wr_latch | input | 1 | Write enable latch from the status logic |
| wr_latch_clr | output | 1 | One-cycle request to clear the write enable latch |
| busy | output | 1 | Write cycle in progress |
| mem_addr | output | AW | RAM address |
| mem_rd_en | output | 1 | RAM read strobe; data arrives on the next cycle |
| mem_rdata | input | 8 | RAM read data |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |

## Verification
Reads are tried from a mid-array address, from an address just below the top with bit 7 set, and right after writes. Together these separate correct address advance, top-of-array wrap, ignored high address bits and actual array updates. Writes are tried as a short run inside a page, a run that passes the page end, and runs under each protect setting at addresses on both sides of the region edge. Refused writes are tried with the latch clear, with select rising mid-byte, with no data byte, while busy and with an unknown opcode. A model array compared with the RAM on every clock shows whether a refusal really left the array alone and whether an accepted write landed only after select rose.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam int         PAGE_BYTES = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD,
        ST_WR,
        ST_DISCARD,
        ST_COMMIT,
        ST_HOLDOFF
    } seq_state_e;
endpackage

// File: rtl/spi_seq_rx.sv
// Serial front end: synchronises the pins, detects edges, assembles bytes.
module spi_seq_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    output logic       cs_low,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       sck_rise,
    output logic       sck_fall,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic [2:0] bit_cnt
);
    logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
    logic sck_s, mosi_s, sck_d, cs_low_d;
    logic [6:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
            sck_d    <= 1'b0;
            cs_low_d <= 1'b0;
        end else begin
            sck_p  <= {sck_p[SYNC_STAGES-2:0], sck_i};
            cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n_i};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi_i};
            sck_d    <= sck_s;
            cs_low_d <= cs_low;
        end
    end

    assign sck_s    = sck_p[SYNC_STAGES-1];
    assign mosi_s   = mosi_p[SYNC_STAGES-1];
    assign cs_low   = ~cs_p[SYNC_STAGES-1];
    assign sck_rise = cs_low & sck_s & ~sck_d;
    assign sck_fall = cs_low & ~sck_s & sck_d;
    assign cs_fall  = cs_low & ~cs_low_d;
    assign cs_rise  = ~cs_low & cs_low_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            bit_cnt    <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (!cs_low) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                sh      <= {sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {sh, mosi_s};
                end
            end
        end
    end

    // a deselect always restarts byte framing (R8)
    assert_frame_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/spi_seq_pagebuf.sv
// Page write buffer: circular slot pointer and one valid flag per slot.
module spi_seq_pagebuf #(
    parameter int PAGE = 16,
    localparam int PW  = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] start_ptr,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic [PW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          rd_vld,
    output logic          any_vld
);
    logic [7:0]      slot [PAGE];
    logic [PAGE-1:0] vld;
    logic [PW-1:0]   ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (start) begin
            vld <= '0;
            ptr <= start_ptr;
        end else if (push) begin
            vld[ptr] <= 1'b1;
            ptr      <= ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !start) slot[ptr] <= push_data;
    end

    assign rd_data = slot[rd_idx];
    assign rd_vld  = vld[rd_idx];
    assign any_vld = |vld;

    // a pushed byte always occupies a slot of the page (R5)
    assert_push_marks_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !start) |=> any_vld);
endmodule

// File: rtl/spi_seq_tx.sv
// Output shifter with a one-byte prefetch register.
module spi_seq_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       pf_wr,
    input  logic [7:0] pf_data,
    input  logic       adv,
    input  logic       shift,
    output logic       bit_o
);
    logic [7:0] tx, pf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx <= '0;
            pf <= '0;
        end else begin
            if (load)       tx <= load_data;
            else if (adv)   tx <= pf;
            else if (shift) tx <= {tx[6:0], 1'b0};
            if (pf_wr)      pf <= pf_data;
        end
    end

    assign bit_o = tx[7];
endmodule

// File: rtl/spi_array_seq.sv
module spi_array_seq
    import spi_seq_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int WR_CYCLES   = 200,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    input  logic [1:0]    prot_bits,
    input  logic          wr_latch,
    output logic          wr_latch_clr,
    output logic          busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    input  logic [7:0]    mem_rdata,
    output logic          mem_wr_en,
    output logic [7:0]    mem_wdata
);
    // front end
    logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall, byte_valid;
    logic [7:0] rx_byte;
    logic [2:0] bit_cnt;

    spi_seq_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .bit_cnt(bit_cnt)
    );

    // sequencer state
    seq_state_e    state_q, state_d;
    logic          op_wr_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    prot_q;
    logic          rd_pend_q, rd_dst_q, rd_started_q, tx_live_q;
    logic [PW-1:0] idx_q;
    logic [CW-1:0] hold_q;

    // decoded strobes
    logic buf_start, buf_push, tx_load, tx_pf_wr, tx_adv, tx_shift;
    logic [7:0] buf_data;
    logic buf_vld, buf_any;
    logic addr_hit;

    function automatic logic prot_hit(input logic [AW-1:0] a, input logic [1:0] bp);
        unique case (bp)
            2'b00:   prot_hit = 1'b0;
            2'b01:   prot_hit = a[AW-1] & a[AW-2];
            2'b10:   prot_hit = a[AW-1];
            default: prot_hit = 1'b1;
        endcase
    endfunction

    assign addr_hit = prot_hit(rx_byte[AW-1:0], prot_bits);

    spi_seq_pagebuf #(.PAGE(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .start(buf_start), .start_ptr(rx_byte[PW-1:0]),
        .push(buf_push), .push_data(rx_byte),
        .rd_idx(idx_q), .rd_data(buf_data), .rd_vld(buf_vld), .any_vld(buf_any)
    );

    assign tx_load  = rd_pend_q & ~rd_dst_q & (state_q == ST_RD);
    assign tx_pf_wr = rd_pend_q & rd_dst_q;

    spi_seq_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(tx_load), .load_data(mem_rdata),
        .pf_wr(tx_pf_wr), .pf_data(mem_rdata),
        .adv(tx_adv), .shift(tx_shift), .bit_o(spi_miso)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cs_fall) state_d = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_rise) state_d = ST_IDLE;
                else if (byte_valid) begin
                    if (rx_byte == OP_READ)                    state_d = ST_ADDR;
                    else if (rx_byte == OP_WRITE && wr_latch)  state_d = ST_ADDR;
                    else                                       state_d = ST_DISCARD;
                end
            end
            ST_ADDR: begin
                if (cs_rise) state_d = ST_IDLE;
                else if (byte_valid) begin
                    if (!op_wr_q)      state_d = ST_RD;
                    else if (addr_hit) state_d = ST_DISCARD;
                    else               state_d = ST_WR;
                end
            end
            ST_RD:      if (cs_rise) state_d = ST_IDLE;
            ST_WR: begin
                if (cs_rise)
                    state_d = (bit_cnt == 3'd0 && buf_any) ? ST_COMMIT : ST_IDLE;
            end
            ST_DISCARD: if (cs_rise) state_d = ST_IDLE;
            ST_COMMIT:  if (idx_q == PW'(PAGE_BYTES - 1)) state_d = ST_HOLDOFF;
            ST_HOLDOFF: if (hold_q == CW'(WR_CYCLES - 1)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        mem_rd_en    = 1'b0;
        mem_wr_en    = 1'b0;
        mem_addr     = addr_q;
        mem_wdata    = buf_data;
        buf_start    = 1'b0;
        buf_push     = 1'b0;
        tx_adv       = 1'b0;
        tx_shift     = 1'b0;
        busy         = 1'b0;
        wr_latch_clr = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                if (byte_valid && !op_wr_q) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = rx_byte[AW-1:0];
                end
                if (byte_valid && op_wr_q && !addr_hit) buf_start = 1'b1;
            end
            ST_RD: begin
                if (tx_load) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = addr_q + AW'(1);
                end else if (sck_fall && rd_started_q) begin
                    if (bit_cnt == 3'd0) begin
                        tx_adv    = 1'b1;
                        mem_rd_en = 1'b1;
                        mem_addr  = addr_q + AW'(1);
                    end else begin
                        tx_shift = 1'b1;
                    end
                end
            end
            ST_WR:      buf_push = byte_valid;
            ST_COMMIT: begin
                busy      = 1'b1;
                mem_wr_en = buf_vld;
                mem_addr  = {addr_q[AW-1:PW], idx_q};
            end
            ST_HOLDOFF: begin
                busy         = 1'b1;
                wr_latch_clr = (hold_q == CW'(WR_CYCLES - 1));
            end
            default: ;
        endcase
    end

    assign spi_miso_oe = ~spi_cs_n & (state_q == ST_RD) & tx_live_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_q      <= 1'b0;
            addr_q       <= '0;
            prot_q       <= '0;
            rd_pend_q    <= 1'b0;
            rd_dst_q     <= 1'b0;
            rd_started_q <= 1'b0;
            tx_live_q    <= 1'b0;
            idx_q        <= '0;
            hold_q       <= '0;
        end else begin
            rd_pend_q <= mem_rd_en;
            rd_dst_q  <= (state_q == ST_RD);
            if (state_q == ST_OPCODE && byte_valid) op_wr_q <= (rx_byte == OP_WRITE);
            if (state_q == ST_ADDR && byte_valid) begin
                prot_q <= prot_bits;
                addr_q <= op_wr_q ? {rx_byte[AW-1:PW], PW'(0)} : rx_byte[AW-1:0];
            end else if (state_q == ST_RD && mem_rd_en) begin
                addr_q <= addr_q + AW'(1);
            end
            if (state_q != ST_RD) begin
                rd_started_q <= 1'b0;
                tx_live_q    <= 1'b0;
            end else begin
                if (sck_rise) rd_started_q <= 1'b1;
                if (tx_load)  tx_live_q    <= 1'b1;
            end
            idx_q  <= (state_q == ST_COMMIT)  ? idx_q + PW'(1)  : '0;
            hold_q <= (state_q == ST_HOLDOFF) ? hold_q + CW'(1) : '0;
        end
    end

    // a write cycle only starts once select is seen high (R4)
    assert_commit_after_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !cs_low);

    // no RAM write into the region protected when the address was taken (R6)
    assert_no_protected_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !prot_hit(mem_addr, prot_q));

    // streaming out never overlaps a write cycle (R9)
    assert_read_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (!busy && !mem_wr_en));

    // the clear request is the last busy cycle (R11)
    assert_clear_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_clr |=> !busy);

    // busy never ends without a clear request (R11)
    assert_busy_end_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_latch_clr));
endmodule

// File: tb/tb_spi_array_seq.sv
module tb_spi_array_seq;
    localparam int DEPTH = 128;
    localparam int WRC   = 1000;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [1:0] prot_bits = 2'b00;
    logic wr_latch = 1'b0;
    logic wr_latch_clr, busy;
    logic [AW-1:0] mem_addr;
    logic mem_rd_en, mem_wr_en;
    logic [7:0] mem_rdata, mem_wdata;

    always #2 clk = ~clk;

    spi_array_seq #(.DEPTH(DEPTH), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .prot_bits(prot_bits),
        .wr_latch(wr_latch), .wr_latch_clr(wr_latch_clr), .busy(busy),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    // array RAM
    logic [7:0] ram [DEPTH];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= 8'((i * 37 + 11) & 255);
        end else begin
            if (mem_wr_en) ram[mem_addr] <= mem_wdata;
            if (mem_rd_en) mem_rdata <= ram[mem_addr];
        end
    end

    // behavioural model and bench state (driven from the stimulus process only)
    logic [7:0] model [DEPTH];
    bit cmp_en = 1'b0;
    bit oe_any;
    int tb_checks = 0, tb_fails = 0;

    // per-clock monitor
    int mon_checks = 0, mon_fails = 0;
    int busy_rises = 0, busy_cycles = 0, clr_pulses = 0;
    logic busy_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_d) busy_rises++;
            if (busy) busy_cycles++;
            if (wr_latch_clr) clr_pulses++;
            busy_d <= busy;
            mon_checks++;
            if (spi_cs_n && spi_miso_oe) begin
                mon_fails++;
                $display("FAIL R10: output enabled while deselected, actual=1 expected=0");
            end
            if (cmp_en) begin
                int bad;
                bad = -1;
                for (int i = 0; i < DEPTH; i++) if (bad < 0 && ram[i] !== model[i]) bad = i;
                mon_checks++;
                if (bad >= 0) begin
                    mon_fails++;
                    $display("FAIL R4 R6 R7 R8 R9 R10: array[%0d] actual=%02h expected=%02h",
                             bad, ram[bad], model[bad]);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tb_checks++;
        if (!ok) begin
            tb_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] o, input int nb, output logic [7:0] i);
        i = 8'h00;
        for (int b = 7; b >= 8 - nb; b--) begin
            spi_mosi = o[b];
            clocks(HALF);
            i[b] = spi_miso;
            if (spi_miso_oe) oe_any = 1'b1;
            spi_sck = 1'b1;
            clocks(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic sel();
        spi_cs_n = 1'b0;
        clocks(HALF);
    endtask

    task automatic desel();
        clocks(HALF);
        spi_cs_n = 1'b1;
        clocks(2 * HALF);
    endtask

    function automatic bit model_prot(input int a, input logic [1:0] bp);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= (DEPTH * 3) / 4;
            2'b10:   return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic apply(input int a, input logic [7:0] d[$]);
        int base, p;
        base = (a % DEPTH) & ~15;
        p = a & 15;
        foreach (d[k]) model[base + ((p + k) % 16)] = d[k];
    endtask

    task automatic do_read(input logic [7:0] a, input int n, input string tag);
        logic [7:0] r;
        sel();
        oe_any = 1'b0;
        xfer(8'h03, 8, r);
        xfer(a, 8, r);
        check(!oe_any, "R10 no output in opcode/address", oe_any, 0);
        for (int k = 0; k < n; k++) begin
            int ea;
            oe_any = 1'b0;
            xfer(8'h00, 8, r);
            ea = (int'(a) + k) % DEPTH;
            check(oe_any && r == model[ea], tag, r, model[ea]);
        end
        desel();
        check(!spi_miso_oe, "R10 output off after deselect", spi_miso_oe, 0);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d[$], input int tail, input string tag);
        logic [7:0] r;
        bit acc;
        int r0, c0, b0, wd;
        acc = wr_latch && !model_prot(int'(a) % DEPTH, prot_bits) && d.size() > 0 && tail == 0;
        sel();
        xfer(8'h02, 8, r);
        xfer(a, 8, r);
        foreach (d[k]) xfer(d[k], 8, r);
        if (tail != 0) xfer(8'hA5, tail, r);
        r0 = busy_rises; c0 = clr_pulses; b0 = busy_cycles;
        if (acc) cmp_en = 1'b0;
        desel();
        if (acc) begin
            wd = 0;
            while ((busy_rises == r0 || busy) && wd < 5000) begin clocks(1); wd++; end
            check(busy_rises == r0 + 1, {tag, " R4 write started"}, busy_rises - r0, 1);
            check(busy_cycles - b0 == 16 + WRC, "R9 busy length", busy_cycles - b0, 16 + WRC);
            check(clr_pulses - c0 == 1, "R11 one clear pulse", clr_pulses - c0, 1);
            apply(a, d);
            cmp_en = 1'b1;
            clocks(2);
        end else begin
            clocks(40);
            check(busy_rises == r0, {tag, " write refused"}, busy_rises - r0, 0);
        end
    endtask

    // watchdog
    initial begin
        clocks(150000);
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 tb_checks + mon_checks + 1, tb_fails + mon_fails + 1);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] q[$];
        for (int i = 0; i < DEPTH; i++) model[i] = 8'((i * 37 + 11) & 255);
        clocks(3);
        // R1 reset values
        check(busy == 1'b0 && spi_miso_oe == 1'b0 && wr_latch_clr == 1'b0 && mem_wr_en == 1'b0,
              "R1 reset outputs", {busy, spi_miso_oe, wr_latch_clr, mem_wr_en}, 0);
        rst_n = 1'b1;
        clocks(4);
        check(busy == 1'b0 && spi_miso_oe == 1'b0, "R1 after reset", {busy, spi_miso_oe}, 0);
        cmp_en = 1'b1;

        // R2 streaming read
        do_read(8'h10, 5, "R2 sequential read");
        // R3 top wrap with bit 7 ignored
        do_read(8'hFE, 4, "R3 wrap and masked address");

        // R4 short write, then read back
        wr_latch = 1'b1;
        q = '{8'hA1, 8'hB2, 8'hC3};
        do_write(8'h23, q, 0, "R4");
        do_read(8'h22, 5, "R4 read back");

        // R5 page wrap
        q = {};
        for (int k = 0; k < 20; k++) q.push_back(8'(8'h40 + k * 3));
        do_write(8'h45, q, 0, "R5");
        do_read(8'h40, 16, "R5 page wrap read back");

        // R6 protection
        q = '{8'h77};
        prot_bits = 2'b01;
        do_write(8'h70, q, 0, "R6 top quarter");
        do_write(8'h50, q, 0, "R6 below quarter");
        prot_bits = 2'b10;
        do_write(8'h40, q, 0, "R6 top half");
        prot_bits = 2'b11;
        do_write(8'h05, q, 0, "R6 whole array");
        prot_bits = 2'b00;
        do_read(8'h4E, 4, "R6 read back");

        // R7 latch clear
        wr_latch = 1'b0;
        do_write(8'h10, q, 0, "R7 latch clear");
        wr_latch = 1'b1;

        // R8 partial byte and no data byte
        do_write(8'h30, q, 4, "R8 mid-byte deselect");
        q = {};
        do_write(8'h31, q, 0, "R8 no data byte");
        do_read(8'h30, 2, "R8 read back");

        // R9 instructions during busy
        begin
            int r0, b0, c0, wd;
            r0 = busy_rises; b0 = busy_cycles; c0 = clr_pulses;
            sel(); xfer(8'h02, 8, r); xfer(8'h08, 8, r); xfer(8'h5A, 8, r);
            cmp_en = 1'b0;
            desel();
            check(busy == 1'b1, "R9 busy after write", busy, 1);
            sel(); xfer(8'h02, 8, r); xfer(8'h60, 8, r); xfer(8'h11, 8, r); desel();
            sel(); oe_any = 1'b0;
            xfer(8'h03, 8, r); xfer(8'h00, 8, r); xfer(8'h00, 8, r); desel();
            check(!oe_any, "R9 read ignored while busy", oe_any, 0);
            check(busy == 1'b1, "R9 still busy", busy, 1);
            wd = 0;
            while (busy && wd < 5000) begin clocks(1); wd++; end
            check(busy_rises - r0 == 1, "R9 single write cycle", busy_rises - r0, 1);
            check(busy_cycles - b0 == 16 + WRC, "R9 busy length", busy_cycles - b0, 16 + WRC);
            check(clr_pulses - c0 == 1, "R11 clear pulse", clr_pulses - c0, 1);
            q = '{8'h5A};
            apply(8'h08, q);
            cmp_en = 1'b1;
            clocks(2);
            do_read(8'h60, 1, "R9 refused byte unchanged");
        end

        // R10 unknown opcode
        begin
            int r0;
            r0 = busy_rises;
            sel(); oe_any = 1'b0;
            xfer(8'h05, 8, r); xfer(8'h10, 8, r); xfer(8'hFF, 8, r); xfer(8'h00, 8, r);
            desel();
            clocks(20);
            check(!oe_any, "R10 unknown opcode silent", oe_any, 0);
            check(busy_rises == r0, "R10 unknown opcode no write", busy_rises - r0, 0);
        end

        clocks(10);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 tb_checks + mon_checks, tb_fails + mon_fails);
        $finish;
    end
endmodule